// File: doc/BRIEF.md
# Table-Access Program Memory Self-Programming Controller

This block lets a processor read, load and reprogram its own 24-bit-wide program memory while running. The memory is held in an internal register array that stands in for flash. Every access names its target with a 24-bit table address, made from an 8-bit page register above a 16-bit effective address. Each instruction word spans two address units, and the 24-bit word is reached through two lanes: a low lane covering bits 15:0 and a high lane covering bits 23:16. Either lane can be used in word mode or in byte mode.

Table writes never touch the array directly. They fill a row latch that holds one row of instruction words. A command then commits the whole latch to an aligned row, or one latch slot to a single word. Another command erases a whole aligned page to all ones. Programming can only clear bits, so each committed word becomes the old word ANDed with the latch word. While a command is running, a busy flag is held for a fixed number of cycles. Any table write or command that arrives during that time is dropped and raises an error flag.

Top module: `tblFlash`

## Requirements
- R1: The table address is {tblPage, effAddr}, and bit 23 (tblPage[7]) selects configuration space when it is 1. In configuration space, reads return 0x0000 and table writes are ignored. Commands there are also ignored (busy stays low), and both table writes and commands set errFlag.
- R2: In word mode (byteMode=0), a low-lane read (hiLane=0) returns bits 15:0 of the word at index address[10:1]. In byte mode it returns bits 7:0 when address bit 0 is 0 and bits 15:8 when it is 1, zero-extended to 16 bits.
- R3: A high-lane read (hiLane=1) returns bits 23:16 zero-extended, in word mode and in byte mode with address bit 0 = 0. In byte mode with address bit 0 = 1 it returns 0x0000, and a table write in that mode is ignored.
- R4: A table write only loads latch slot (word index mod 64), and it does not change the array. The low-lane word mode loads bits 15:0 from wrData. The low-lane byte mode loads wrData[7:0] into bits 7:0 (address bit 0 = 0) or into bits 15:8 (address bit 0 = 1). The high lane loads wrData[7:0] into bits 23:16.
- R5: Command code 2'b01 (row program) sets every word of the 64-word-aligned row that holds the target to old AND latch[slot].
- R6: Command code 2'b10 (word program) sets only the target word to old AND latch[target index mod 64].
- R7: Command code 2'b11 (page erase) sets every word of the 512-word-aligned page that holds the target to 0xFFFFFF, and it leaves every other page unchanged. Code 2'b00 does nothing.
- R8: When a program command ends, every latch slot is all ones. A later program with no table writes in between therefore changes nothing.
- R9: busy rises in the cycle after a command is accepted and stays high for exactly BUSY_CYCLES cycles.
- R10: A table write or command presented while busy is high is ignored and sets errFlag. errFlag stays set until the next accepted command clears it.
- R11: After reset, busy, errFlag and rdValid are low, every array word reads as erased (0xFFFFFF), and the latch is all ones.
- R12: A table write presented in the same cycle as an accepted program command is included in that commit.
- R13: rdValid is high exactly one cycle after rdEn, with rdData valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tblPage | input | 8 | Page register, table address bits 23:16 |
| effAddr | input | 16 | Effective address, table address bits 15:0 |
| hiLane | input | 1 | 1 selects bits 23:16, 0 selects bits 15:0 |
| byteMode | input | 1 | 1 for a byte access, 0 for a word access |
| rdEn | input | 1 | Table read request |
| rdData | output | 16 | Read result, zero-extended |
| rdValid | output | 1 | rdData valid |
| wrEn | input | 1 | Table write request into the row latch |
| wrData | input | 16 | Table write data |
| cmdValid | input | 1 | Command request |
| cmdOp | input | 2 | 00 none, 01 row program, 10 word program, 11 page erase |
| busy | output | 1 | Command in progress |
| errFlag | output | 1 | A write or command was rejected |

## Verification
Two things can happen in the same cycle: a table write into the latch and the acceptance of a program command. The commit only starts reading the latch on the next cycle, so the new write must be part of the committed word. The bench provokes this by asserting wrEn and cmdValid together on one address. It then reads the word back through the scoreboard and expects the value written in that cycle rather than the erased value. The bench also presents writes and commands at the start of a busy period. It judges that they were dropped by reading back the array afterwards and by watching errFlag.

// File: rtl/flash_pkg.sv
package flash_pkg;

  localparam int LO_W   = 16;
  localparam int HI_W   = 8;
  localparam int WORD_W = LO_W + HI_W;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_ROW   = 2'b01,
    CMD_WORD  = 2'b10,
    CMD_ERASE = 2'b11
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latWe;    // accepted table write into the latch
    logic stepEn;   // one array word is processed this cycle
    logic progEn;   // step is an AND-program
    logic eraseEn;  // step is an erase
    logic latClr;   // reload the latch with all ones
  } stb_t;

endpackage

// File: rtl/flashCtrl.sv
module flashCtrl
  import flash_pkg::*;
#(
  parameter int IDX_W       = 10,
  parameter int ROW_WORDS   = 64,
  parameter int PAGE_WORDS  = 512,
  parameter int BUSY_CYCLES = 600
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgSpace,
  input  logic [IDX_W-1:0] wordIdx,
  input  logic             wrEn,
  input  logic             cmdValid,
  input  cmd_e             cmdOp,
  output logic             busy,
  output logic             errFlag,
  output logic [IDX_W-1:0] stepAddr,
  output stb_t             stb
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [IDX_W-1:0] ROW_MASK  = ~(IDX_W'(ROW_WORDS - 1));
  localparam logic [IDX_W-1:0] PAGE_MASK = ~(IDX_W'(PAGE_WORDS - 1));
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(BUSY_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  cmd_e             curOp;
  logic [IDX_W-1:0] baseIdx;
  logic [31:0]      nWords;
  logic             accept, reject, isProg;

  assign accept = cmdValid && !busy && !cfgSpace && (cmdOp != CMD_NONE);
  assign reject = (busy && (wrEn || cmdValid)) ||
                  (!busy && cfgSpace && (wrEn || (cmdValid && cmdOp != CMD_NONE)));

  always_comb begin
    case (curOp)
      CMD_ROW:   nWords = 32'(ROW_WORDS);
      CMD_WORD:  nWords = 32'd1;
      CMD_ERASE: nWords = 32'(PAGE_WORDS);
      default:   nWords = 32'd0;
    endcase
  end

  assign isProg      = (curOp == CMD_ROW) || (curOp == CMD_WORD);
  assign stepAddr    = baseIdx + IDX_W'(cnt);
  assign stb.latWe   = wrEn && !busy && !cfgSpace;
  assign stb.stepEn  = busy && (32'(cnt) < nWords);
  assign stb.progEn  = isProg;
  assign stb.eraseEn = (curOp == CMD_ERASE);
  assign stb.latClr  = busy && isProg && (cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      cnt     <= '0;
      curOp   <= CMD_NONE;
      baseIdx <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      cnt   <= '0;
      curOp <= cmdOp;
      case (cmdOp)
        CMD_ROW:   baseIdx <= wordIdx & ROW_MASK;
        CMD_ERASE: baseIdx <= wordIdx & PAGE_MASK;
        default:   baseIdx <= wordIdx;
      endcase
    end else if (busy) begin
      if (cnt == LAST_CNT) busy <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)       errFlag <= 1'b0;
    else if (accept) errFlag <= 1'b0;
    else if (reject) errFlag <= 1'b1;
  end

  // R9: busy starts only from a presented command
  a_r9_busy_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdValid));
  // R9: busy ends after the full count
  a_r9_busy_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(cnt) == LAST_CNT);
  // R10: a write while busy raises the error
  a_r10_busy_write_err: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn) |=> errFlag);
  // R1: a command in configuration space never starts
  a_r1_cfg_no_start: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cfgSpace && !busy) |=> !busy);

endmodule

// File: rtl/flashData.sv
module flashData
  import flash_pkg::*;
#(
  parameter int IDX_W     = 10,
  parameter int MEM_WORDS = 1024,
  parameter int ROW_WORDS = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  stb_t             stb,
  input  logic [IDX_W-1:0] stepAddr,
  input  logic [IDX_W-1:0] wordIdx,
  input  logic             cfgSpace,
  input  logic             hiLane,
  input  logic             byteMode,
  input  logic             byteSel,
  input  logic             rdEn,
  input  logic [LO_W-1:0]  wrData,
  output logic [LO_W-1:0]  rdData,
  output logic             rdValid
);

  localparam int ROW_W = $clog2(ROW_WORDS);

  logic [WORD_W-1:0] mem   [MEM_WORDS];
  logic [WORD_W-1:0] latch [ROW_WORDS];
  logic [WORD_W-1:0] rdWord;
  logic [LO_W-1:0]   rdNext;
  logic [ROW_W-1:0]  wrSlot, stepSlot;

  assign wrSlot   = wordIdx[ROW_W-1:0];
  assign stepSlot = stepAddr[ROW_W-1:0];

  // program array: AND-program or erase one word per step
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= '1;
    end else if (stb.stepEn) begin
      if (stb.eraseEn)     mem[stepAddr] <= '1;
      else if (stb.progEn) mem[stepAddr] <= mem[stepAddr] & latch[stepSlot];
    end
  end

  // row latch with lane and byte steering
  always_ff @(posedge clk) begin
    if (!rstN || stb.latClr) begin
      for (int i = 0; i < ROW_WORDS; i++) latch[i] <= '1;
    end else if (stb.latWe) begin
      if (!hiLane) begin
        if (!byteMode)   latch[wrSlot][15:0]  <= wrData;
        else if (byteSel) latch[wrSlot][15:8] <= wrData[7:0];
        else              latch[wrSlot][7:0]  <= wrData[7:0];
      end else if (!byteMode || !byteSel) begin
        latch[wrSlot][23:16] <= wrData[7:0];
      end
    end
  end

  always_comb begin
    rdWord = mem[wordIdx];
    rdNext = '0;
    if (!cfgSpace) begin
      if (!hiLane) begin
        if (!byteMode)    rdNext = rdWord[15:0];
        else if (byteSel) rdNext = {8'h00, rdWord[15:8]};
        else              rdNext = {8'h00, rdWord[7:0]};
      end else if (!byteMode || !byteSel) begin
        rdNext = {8'h00, rdWord[23:16]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) rdData <= rdNext;
    end
  end

  // R3: missing upper byte reads as zero
  a_r3_hi_byte1_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && hiLane && byteMode && byteSel) |=> rdData == '0);
  // R1: configuration space reads as zero
  a_r1_cfg_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && cfgSpace) |=> rdData == '0);
  // R8: latch fully reloaded after a program
  a_r8_latch_clear: assert property (@(posedge clk) disable iff (!rstN)
    stb.latClr |=> (latch[0] == '1 && latch[ROW_WORDS-1] == '1));

endmodule

// File: rtl/tblFlash.sv
module tblFlash
  import flash_pkg::*;
#(
  parameter int PAGE_W      = 8,
  parameter int EA_W        = 16,
  parameter int MEM_WORDS   = 1024,
  parameter int ROW_WORDS   = 64,
  parameter int PAGE_WORDS  = 512,
  parameter int BUSY_CYCLES = 600
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PAGE_W-1:0] tblPage,
  input  logic [EA_W-1:0]   effAddr,
  input  logic              hiLane,
  input  logic              byteMode,
  input  logic              rdEn,
  output logic [LO_W-1:0]   rdData,
  output logic              rdValid,
  input  logic              wrEn,
  input  logic [LO_W-1:0]   wrData,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  output logic              busy,
  output logic              errFlag
);

  localparam int ADDR_W = PAGE_W + EA_W;
  localparam int IDX_W  = $clog2(MEM_WORDS);

  logic [ADDR_W-1:0] fullAddr;
  logic [IDX_W-1:0]  wordIdx, stepAddr;
  logic              cfgSpace, byteSel, unusedAddr;
  stb_t              stb;

  assign fullAddr   = {tblPage, effAddr};
  assign cfgSpace   = fullAddr[ADDR_W-1];
  assign byteSel    = fullAddr[0];
  assign wordIdx    = fullAddr[IDX_W:1];
  assign unusedAddr = ^fullAddr[ADDR_W-2:IDX_W+1];

  flashCtrl #(
    .IDX_W(IDX_W), .ROW_WORDS(ROW_WORDS),
    .PAGE_WORDS(PAGE_WORDS), .BUSY_CYCLES(BUSY_CYCLES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgSpace(cfgSpace), .wordIdx(wordIdx),
    .wrEn(wrEn), .cmdValid(cmdValid), .cmdOp(cmd_e'(cmdOp)),
    .busy(busy), .errFlag(errFlag), .stepAddr(stepAddr), .stb(stb)
  );

  flashData #(
    .IDX_W(IDX_W), .MEM_WORDS(MEM_WORDS), .ROW_WORDS(ROW_WORDS)
  ) i_data (
    .clk(clk), .rstN(rstN), .stb(stb), .stepAddr(stepAddr),
    .wordIdx(wordIdx), .cfgSpace(cfgSpace), .hiLane(hiLane),
    .byteMode(byteMode), .byteSel(byteSel), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: tb/test_tblFlash.sv
module test_tblFlash;

  localparam int MEM = 1024;
  localparam int ROW = 64;
  localparam int PG  = 512;
  localparam int BUSYN = 600;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  tblPage = '0;
  logic [15:0] effAddr = '0;
  logic        hiLane = 1'b0, byteMode = 1'b0, rdEn = 1'b0, wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = '0;
  logic [15:0] rdData;
  logic        rdValid, busy, errFlag;

  int nChk = 0, nFail = 0;
  logic [23:0] mdlMem [MEM];
  logic [23:0] mdlLat [ROW];
  logic [15:0] expQ [$];
  string       tagQ [$];

  always #4 clk = ~clk;  // 125 MHz

  tblFlash i_tblFlash (
    .clk(clk), .rstN(rstN), .tblPage(tblPage), .effAddr(effAddr),
    .hiLane(hiLane), .byteMode(byteMode), .rdEn(rdEn), .rdData(rdData),
    .rdValid(rdValid), .wrEn(wrEn), .wrData(wrData), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .busy(busy), .errFlag(errFlag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expRead(input logic [7:0] pg, input logic [15:0] ea,
                                          input logic hi, input logic bm);
    logic [23:0] w;
    if (pg[7]) return 16'h0000;
    w = mdlMem[int'(ea[10:1])];
    if (!hi) begin
      if (!bm) return w[15:0];
      return ea[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    end
    if (bm && ea[0]) return 16'h0000;
    return {8'h00, w[23:16]};
  endfunction

  function automatic void mdlWrite(input logic [15:0] ea, input logic hi,
                                   input logic bm, input logic [15:0] d);
    int s = int'(ea[6:1]);
    if (!hi) begin
      if (!bm)        mdlLat[s][15:0] = d;
      else if (ea[0]) mdlLat[s][15:8] = d[7:0];
      else            mdlLat[s][7:0]  = d[7:0];
    end else if (!bm || !ea[0]) begin
      mdlLat[s][23:16] = d[7:0];
    end
  endfunction

  function automatic void mdlCmd(input logic [1:0] op, input logic [15:0] ea);
    int idx = int'(ea[10:1]);
    case (op)
      2'b01: begin
        for (int i = 0; i < ROW; i++) mdlMem[(idx / ROW) * ROW + i] &= mdlLat[i];
        for (int i = 0; i < ROW; i++) mdlLat[i] = '1;
      end
      2'b10: begin
        mdlMem[idx] &= mdlLat[idx % ROW];
        for (int i = 0; i < ROW; i++) mdlLat[i] = '1;
      end
      2'b11: for (int i = 0; i < PG; i++) mdlMem[(idx / PG) * PG + i] = '1;
      default: ;
    endcase
  endfunction

  // driver tasks: start and end at a falling edge
  task automatic tblRead(input logic [7:0] pg, input logic [15:0] ea,
                         input logic hi, input logic bm, input string tag);
    tblPage = pg; effAddr = ea; hiLane = hi; byteMode = bm; rdEn = 1'b1;
    expQ.push_back(expRead(pg, ea, hi, bm));
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic tblWrite(input logic [7:0] pg, input logic [15:0] ea,
                          input logic hi, input logic bm, input logic [15:0] d);
    tblPage = pg; effAddr = ea; hiLane = hi; byteMode = bm; wrData = d; wrEn = 1'b1;
    if (!pg[7] && !busy) mdlWrite(ea, hi, bm, d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runCmd(input logic [1:0] op, input logic [15:0] ea, input string tag);
    int n = 0;
    tblPage = 8'h00; effAddr = ea; cmdOp = op; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    mdlCmd(op, ea);
    while (busy && n < 5000) begin
      n++;
      @(negedge clk);
    end
    chk({"R9 busy length ", tag}, n, BUSYN);
  endtask

  // monitor: scoreboard of read results
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        chk("R13 rdValid without a pending read", 1, 0);
      end else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, rdData, e);
      end
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    for (int i = 0; i < MEM; i++) mdlMem[i] = '1;
    for (int i = 0; i < ROW; i++) mdlLat[i] = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk("R11 busy after reset", busy, 0);
    chk("R11 errFlag after reset", errFlag, 0);
    chk("R11 rdValid after reset", rdValid, 0);
    tblRead(8'h00, 16'h0000, 1'b0, 1'b0, "R11 erased low word");
    tblRead(8'h00, 16'h0400, 1'b1, 1'b0, "R11 erased high word");

    // R4: table writes fill the latch only
    tblWrite(8'h00, 16'h0000, 1'b0, 1'b0, 16'h1234);
    tblWrite(8'h00, 16'h0000, 1'b1, 1'b0, 16'h0056);
    tblWrite(8'h00, 16'h0002, 1'b0, 1'b1, 16'h00AB);
    tblWrite(8'h00, 16'h0003, 1'b0, 1'b1, 16'h00CD);
    tblWrite(8'h00, 16'h0004, 1'b1, 1'b1, 16'h003C);
    tblWrite(8'h00, 16'h0005, 1'b1, 1'b1, 16'h0000);  // R3 ignored
    tblWrite(8'h00, 16'h007E, 1'b0, 1'b0, 16'h0F0F);
    tblRead(8'h00, 16'h0000, 1'b0, 1'b0, "R4 array untouched by table write");
    chk("R4 no busy from table writes", busy, 0);

    // R5: row program from an address inside row 0
    runCmd(2'b01, 16'h0010, "row");
    tblRead(8'h00, 16'h0000, 1'b0, 1'b0, "R5 row word0 low");
    tblRead(8'h00, 16'h0000, 1'b1, 1'b0, "R5 row word0 high");
    tblRead(8'h00, 16'h0002, 1'b0, 1'b1, "R2 low byte 0");
    tblRead(8'h00, 16'h0003, 1'b0, 1'b1, "R2 low byte 1");
    tblRead(8'h00, 16'h0004, 1'b1, 1'b1, "R3 high byte 0");
    tblRead(8'h00, 16'h0005, 1'b1, 1'b1, "R3 high byte 1 reads zero");
    tblRead(8'h00, 16'h0004, 1'b1, 1'b0, "R4 high byte1 write ignored");
    tblRead(8'h00, 16'h007E, 1'b0, 1'b0, "R5 last word of row");
    tblRead(8'h00, 16'h0080, 1'b0, 1'b0, "R5 next row untouched");

    // R8: latch empty after program
    runCmd(2'b01, 16'h0000, "row again");
    tblRead(8'h00, 16'h0000, 1'b0, 1'b0, "R8 reprogram with empty latch");

    // R6: single word program ANDs one slot
    tblWrite(8'h00, 16'h0000, 1'b0, 1'b0, 16'hFF00);
    tblWrite(8'h00, 16'h0006, 1'b0, 1'b0, 16'h0000);
    runCmd(2'b10, 16'h0000, "word");
    tblRead(8'h00, 16'h0000, 1'b0, 1'b0, "R6 word program ANDs old value");
    tblRead(8'h00, 16'h0006, 1'b0, 1'b0, "R6 neighbour slot not committed");
    runCmd(2'b10, 16'h0006, "word empty");
    tblRead(8'h00, 16'h0006, 1'b0, 1'b0, "R8 latch slot cleared");
    tblWrite(8'h00, 16'h0410, 1'b0, 1'b0, 16'h0000);
    runCmd(2'b10, 16'h0410, "word page1");
    tblRead(8'h00, 16'h0410, 1'b0, 1'b0, "R6 word in page 1");

    // R10 and R7: erase page 0, poke it while busy
    tblPage = 8'h00; effAddr = 16'h0000; cmdOp = 2'b11; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    mdlCmd(2'b11, 16'h0000);
    chk("R9 busy rises after accept", busy, 1);
    tblWrite(8'h00, 16'h0006, 1'b0, 1'b0, 16'h0000);
    chk("R10 error on write while busy", errFlag, 1);
    effAddr = 16'h0400; cmdOp = 2'b11; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    while (busy) @(negedge clk);
    chk("R10 error stays set", errFlag, 1);
    tblRead(8'h00, 16'h0000, 1'b0, 1'b0, "R7 erased word0 low");
    tblRead(8'h00, 16'h0000, 1'b1, 1'b0, "R7 erased word0 high");
    tblRead(8'h00, 16'h03FE, 1'b0, 1'b0, "R7 last word of page");
    tblRead(8'h00, 16'h0410, 1'b0, 1'b0, "R10 command while busy ignored");
    runCmd(2'b10, 16'h0006, "word after busy");
    chk("R10 error cleared by accepted command", errFlag, 0);
    tblRead(8'h00, 16'h0006, 1'b0, 1'b0, "R10 write while busy ignored");

    // R1: configuration space
    tblRead(8'h80, 16'h0000, 1'b0, 1'b0, "R1 config read is zero");
    tblWrite(8'h80, 16'h0000, 1'b0, 1'b0, 16'h0000);
    chk("R1 config write sets error", errFlag, 1);
    tblPage = 8'h80; effAddr = 16'h0000; cmdOp = 2'b01; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R1 config command not started", busy, 0);
    tblPage = 8'h00; cmdOp = 2'b00; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R7 no-op code does not start", busy, 0);
    runCmd(2'b10, 16'h0000, "after config");
    tblRead(8'h00, 16'h0000, 1'b0, 1'b0, "R1 config write left latch alone");

    // R12: table write and command in one cycle
    tblPage = 8'h00; effAddr = 16'h0020; hiLane = 1'b0; byteMode = 1'b0;
    wrData = 16'h0BAD; wrEn = 1'b1; cmdOp = 2'b10; cmdValid = 1'b1;
    mdlWrite(16'h0020, 1'b0, 1'b0, 16'h0BAD);
    @(negedge clk);
    wrEn = 1'b0; cmdValid = 1'b0;
    mdlCmd(2'b10, 16'h0020);
    chk("R12 command accepted with write", busy, 1);
    chk("R12 no error for same-cycle write", errFlag, 0);
    while (busy) @(negedge clk);
    tblRead(8'h00, 16'h0020, 1'b0, 1'b0, "R12 same-cycle write committed");

    // R13: no stray valid
    @(negedge clk);
    chk("R13 rdValid low without read", rdValid, 0);
    chk("R13 all reads answered", expQ.size(), 0);
    finishRun();
  end

endmodule